// File: doc/BRIEF.md
# MFM Preamble and Address-Mark Lock Detector

This block sits after the data separator and bit-clock recovery of a disk read channel. It watches the stream of recovered MFM channel bits and finds where a sector field starts. Each field opens with a run of encoded zero bytes, which on the medium is a steady one-zero-one-zero pattern. A single address-mark byte follows the run. That byte is written with one clock transition left out, so its channel word breaks the MFM run-length rule.

The run alone cannot fix slot phase, because zeros and ones look alike when seen out of context. For that reason the block only arms itself when it sees the run. It claims alignment only when one of two illegal 16-slot mark words completes right after the run. When it locks, the block reports which mark it found: the header mark (cylinder and sector fields follow) or the data mark (sector payload follows). It then gives one strobe per 16-slot channel word so that a later deserializer can frame bytes.

Channel bits arrive as a stream. `slot_stb` is the valid qualifier, and there is no ready signal because a spinning medium cannot be paused. The detector therefore takes a bit on every cycle in which `slot_stb` is high, and it never applies back-pressure. `chan_bit` is only looked at when `slot_stb` is high.

Top module: `mfm_am_detect`

## Requirements
- R1: After reset, `locked` is 0, `byte_stb` is 0 and `mark_kind` is 0.
- R2: After at least 32 consecutive accepted slots, each different from the slot before it, the block must see the 16-slot header mark word 0x4489 (first slot in the MSB, taken through its last slot). `locked` then goes to 1 in the cycle after that last slot, with `mark_kind` = 0. `locked` stays 0 while the word is still incomplete.
- R3: The same sequence ending in the data mark word 0x4442 locks with `mark_kind` = 1.
- R4: A run of only 31 alternating slots before a mark word does not lock.
- R5: A mark word that is not preceded by a qualified alternating run does not lock.
- R6: The legal, fully clocked encoding of the same byte (0x44A9) after a qualified run does not lock.
- R7: The mark must complete within 16 slots of the first slot that breaks the alternation. A mark that ends on the 17th slot does not lock, and the search restarts from the run.
- R8: While locked, `byte_stb` pulses for one cycle after every 16th accepted slot counted from the mark's last slot. It stays low at all other times.
- R9: While locked, a mark word arriving in the data changes neither `mark_kind`, `locked` nor the strobe phase.
- R10: A `resync` pulse clears `locked` and `mark_kind` in the next cycle and stops the strobes. Locking again requires a fresh run followed by a mark.
- R11: 64 consecutive cycles without `slot_stb` clear the lock. 63 such cycles leave the lock and the strobe phase intact.
- R12: Cycles with `slot_stb` low are ignored whatever `chan_bit` holds, so a preamble and mark spread out with idle cycles still lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_stb | input | 1 | Valid: `chan_bit` holds one channel slot this cycle |
| chan_bit | input | 1 | Recovered channel bit (1 = flux transition) |
| resync | input | 1 | Drop lock and hunt for a new preamble |
| locked | output | 1 | Slot and byte alignment established |
| mark_kind | output | 1 | 0 = header mark found, 1 = data mark found |
| byte_stb | output | 1 | One-cycle pulse at each 16-slot word boundary |

## Verification
The assertions take `resync` and `slot_stb` to be synchronous single-bit controls that may arrive in any cycle. They assume that channel slots enter the block only through cycles in which `slot_stb` is high. The assertions on lock, kind and strobe spacing therefore hold for any bit pattern. The stimulus changes every input half a cycle away from the sampling edge. It starts each scenario with a `resync` pulse so that the alternation count always begins empty. Idle stretches are kept below the 64-cycle gap limit, except in the scenario that tests that limit.

// File: rtl/mfm_am_pkg.sv
`timescale 1ns/1ps
package mfm_am_pkg;
  typedef enum logic {
    MK_HEADER = 1'b0,
    MK_DATA   = 1'b1
  } mark_kind_e;

  localparam int unsigned CHAN_WORD_W = 16;
endpackage

// File: rtl/mfm_zrun_qual.sv
`timescale 1ns/1ps
// Qualifies the alternating preamble run and opens a bounded window
// in which the address mark has to complete.
module mfm_zrun_qual #(
  parameter int unsigned ZRUN_MIN = 32,
  parameter int unsigned WIN_LEN  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_stb,
  input  logic chan_bit,
  input  logic clr,
  input  logic hold,
  output logic armed
);
  localparam int unsigned RW = $clog2(ZRUN_MIN + 1);
  localparam int unsigned WW = $clog2(WIN_LEN + 1);
  localparam logic [RW-1:0] RUN_TOP  = RW'(ZRUN_MIN);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_LEN - 1);

  logic          prev_bit;
  logic          have_prev;
  logic          in_win;
  logic          alt;
  logic [RW-1:0] run_cnt;
  logic [WW-1:0] win_cnt;

  assign alt   = have_prev && (chan_bit != prev_bit);
  assign armed = (run_cnt == RUN_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_bit  <= 1'b0;
      have_prev <= 1'b0;
      in_win    <= 1'b0;
      run_cnt   <= '0;
      win_cnt   <= '0;
    end else if (clr || hold) begin
      have_prev <= 1'b0;
      in_win    <= 1'b0;
      run_cnt   <= '0;
      win_cnt   <= '0;
    end else if (slot_stb) begin
      prev_bit  <= chan_bit;
      have_prev <= 1'b1;
      if (in_win) begin
        if (win_cnt == WIN_LAST) begin
          in_win  <= 1'b0;
          win_cnt <= '0;
          run_cnt <= '0;
        end else begin
          win_cnt <= win_cnt + 1'b1;
        end
      end else if (alt) begin
        if (!armed) run_cnt <= run_cnt + 1'b1;
      end else if (armed) begin
        in_win  <= 1'b1;
        win_cnt <= WW'(1);
      end else begin
        run_cnt <= '0;
      end
    end
  end

  // R7: the mark window only exists on top of a qualified run
  p_window_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |-> armed);

  // R7: the window closes after its last slot
  p_window_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && slot_stb && win_cnt == WIN_LAST) |=> !in_win);
endmodule

// File: rtl/mfm_mark_match.sv
`timescale 1ns/1ps
// 16-slot shift register compared against both illegal mark words.
module mfm_mark_match #(
  parameter int unsigned       WORD_W   = 16,
  parameter logic [WORD_W-1:0] HDR_WORD = 16'h4489,
  parameter logic [WORD_W-1:0] DAT_WORD = 16'h4442
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_stb,
  input  logic chan_bit,
  output logic hit_hdr,
  output logic hit_dat
);
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] word_nxt;

  assign word_nxt = {shreg[WORD_W-2:0], chan_bit};

  always_ff @(posedge clk) begin
    if (!rst_n)        shreg <= '0;
    else if (slot_stb) shreg <= word_nxt;
  end

  assign hit_hdr = slot_stb && (word_nxt == HDR_WORD);
  assign hit_dat = slot_stb && (word_nxt == DAT_WORD);

  // R2/R3: a slot can match at most one mark kind
  p_one_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_hdr && hit_dat));
endmodule

// File: rtl/mfm_lock_ctl.sv
`timescale 1ns/1ps
// Lock state, mark kind, byte phase and idle-gap supervision.
module mfm_lock_ctl #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned GAP_MAX = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_stb,
  input  logic resync,
  input  logic hit,
  input  logic hit_data,
  output logic clr,
  output logic locked,
  output logic kind,
  output logic byte_stb
);
  localparam int unsigned PW = $clog2(WORD_W);
  localparam int unsigned GW = $clog2(GAP_MAX + 1);
  localparam logic [PW-1:0] PH_LAST  = PW'(WORD_W - 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_MAX - 1);

  logic [PW-1:0] phase;
  logic [GW-1:0] gap_cnt;
  logic          gap_exp;

  assign gap_exp = !slot_stb && (gap_cnt == GAP_LAST);
  assign clr     = resync || gap_exp;

  always_ff @(posedge clk) begin
    if (!rst_n)                  gap_cnt <= '0;
    else if (slot_stb || gap_exp) gap_cnt <= '0;
    else                         gap_cnt <= gap_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      kind     <= mfm_am_pkg::MK_HEADER;
      phase    <= '0;
      byte_stb <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      if (clr) begin
        locked <= 1'b0;
        kind   <= mfm_am_pkg::MK_HEADER;
        phase  <= '0;
      end else if (hit && !locked) begin
        locked <= 1'b1;
        kind   <= hit_data;
        phase  <= '0;
      end else if (locked && slot_stb) begin
        phase    <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        byte_stb <= (phase == PH_LAST);
      end
    end
  end

  p_lock_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(hit));

  p_strobe_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> locked);

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> !byte_stb);

  p_kind_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(kind));

  p_resync_unlocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !locked);

  p_gap_unlocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    gap_exp |=> !locked);
endmodule

// File: rtl/mfm_am_detect.sv
`timescale 1ns/1ps
module mfm_am_detect #(
  parameter int unsigned                         ZRUN_MIN = 32,
  parameter int unsigned                         GAP_MAX  = 64,
  parameter int unsigned                         WORD_W   = mfm_am_pkg::CHAN_WORD_W,
  parameter logic [mfm_am_pkg::CHAN_WORD_W-1:0]  HDR_WORD = 16'h4489,
  parameter logic [mfm_am_pkg::CHAN_WORD_W-1:0]  DAT_WORD = 16'h4442
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_stb,
  input  logic chan_bit,
  input  logic resync,
  output logic locked,
  output logic mark_kind,
  output logic byte_stb
);
  logic armed;
  logic clr;
  logic hit_hdr;
  logic hit_dat;
  logic hit;

  mfm_zrun_qual #(.ZRUN_MIN(ZRUN_MIN), .WIN_LEN(WORD_W)) u_zrun (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_stb (slot_stb),
    .chan_bit (chan_bit),
    .clr      (clr),
    .hold     (locked),
    .armed    (armed)
  );

  mfm_mark_match #(.WORD_W(WORD_W), .HDR_WORD(HDR_WORD), .DAT_WORD(DAT_WORD)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_stb (slot_stb),
    .chan_bit (chan_bit),
    .hit_hdr  (hit_hdr),
    .hit_dat  (hit_dat)
  );

  assign hit = armed && (hit_hdr || hit_dat);

  mfm_lock_ctl #(.WORD_W(WORD_W), .GAP_MAX(GAP_MAX)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_stb (slot_stb),
    .resync   (resync),
    .hit      (hit),
    .hit_data (hit_dat),
    .clr      (clr),
    .locked   (locked),
    .kind     (mark_kind),
    .byte_stb (byte_stb)
  );

  // R5/R6: alignment is never claimed without a qualified run behind it
  p_lock_needs_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(armed));
endmodule

// File: tb/test_mfm_am_detect.sv
`timescale 1ns/1ps
module test_mfm_am_detect;
  localparam int GAP = 64;
  localparam logic [15:0] W_HDR   = 16'h4489;
  localparam logic [15:0] W_DAT   = 16'h4442;
  localparam logic [15:0] W_LEGAL = 16'h44A9;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, slot_stb, chan_bit, resync;
  logic locked, mark_kind, byte_stb;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  mfm_am_detect #(.ZRUN_MIN(32), .GAP_MAX(GAP)) i_mfm_am_detect (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .chan_bit(chan_bit),
    .resync(resync), .locked(locked), .mark_kind(mark_kind), .byte_stb(byte_stb)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic slot(input logic b);
    @(negedge clk); slot_stb = 1'b1; chan_bit = b;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    @(negedge clk); slot_stb = 1'b0;
    for (int i = 0; i < n; i++) begin
      chan_bit = ~chan_bit;
      @(posedge clk); #1;
    end
  endtask

  task automatic do_resync();
    @(negedge clk); slot_stb = 1'b0; resync = 1'b1;
    @(posedge clk); #1; resync = 1'b0;
  endtask

  task automatic pairs(input int n);
    for (int i = 0; i < n; i++) begin slot(1'b1); slot(1'b0); end
  endtask

  // send a mark word; check lock stays low until its last slot
  task automatic mark(input logic [15:0] w, input int exp_lock, input string req);
    for (int i = 15; i >= 1; i--) slot(w[i]);
    chk({req, " early"}, int'(locked), 0);
    slot(w[0]);
    chk(req, int'(locked), exp_lock);
  endtask

  // data slots while locked: strobe only after every 16th slot
  task automatic data_slots(input int n, input int strobes, input string req);
    for (int i = 1; i <= n; i++) begin
      logic b = 1'((i * 5 / 3) % 2);
      slot(b);
      chk(req, int'(byte_stb), (strobes != 0 && i % 16 == 0) ? 1 : 0);
    end
  endtask

  task automatic t_reset();
    chk("R1 locked", int'(locked), 0);
    chk("R1 byte_stb", int'(byte_stb), 0);
    chk("R1 kind", int'(mark_kind), 0);
  endtask

  task automatic t_header();
    do_resync(); slot(1'b0); pairs(16);
    mark(W_HDR, 1, "R2 header lock");
    chk("R2 kind", int'(mark_kind), 0);
    data_slots(48, 1, "R8 strobe");
  endtask

  task automatic t_data();
    do_resync(); slot(1'b0); pairs(16);
    mark(W_DAT, 1, "R3 data lock");
    chk("R3 kind", int'(mark_kind), 1);
  endtask

  task automatic t_short();
    do_resync(); pairs(16);
    mark(W_HDR, 0, "R4 short run");
  endtask

  task automatic t_no_run();
    do_resync(); slot(1'b1); slot(1'b1); slot(1'b0); slot(1'b0); slot(1'b1);
    mark(W_HDR, 0, "R5 no run");
  endtask

  task automatic t_legal();
    do_resync(); slot(1'b0); pairs(16);
    mark(W_LEGAL, 0, "R6 legal word");
  endtask

  task automatic t_late();
    do_resync(); slot(1'b0); pairs(16); slot(1'b0);
    mark(W_HDR, 0, "R7 late mark");
  endtask

  task automatic t_locked_mark();
    do_resync(); slot(1'b0); pairs(16);
    mark(W_HDR, 1, "R9 lock");
    for (int i = 15; i >= 0; i--) begin
      slot(W_DAT[i]);
      chk("R9 strobe phase", int'(byte_stb), (i == 0) ? 1 : 0);
    end
    chk("R9 kind", int'(mark_kind), 0);
    chk("R9 locked", int'(locked), 1);
  endtask

  task automatic t_resync();
    do_resync(); slot(1'b0); pairs(16);
    mark(W_DAT, 1, "R10 lock");
    do_resync();
    chk("R10 unlocked", int'(locked), 0);
    chk("R10 kind", int'(mark_kind), 0);
    data_slots(32, 0, "R10 no strobe");
    mark(W_DAT, 0, "R10 no relock");
  endtask

  task automatic t_gap();
    do_resync(); slot(1'b0); pairs(16);
    mark(W_HDR, 1, "R11 lock");
    idle(GAP - 1);
    chk("R11 short gap", int'(locked), 1);
    data_slots(16, 1, "R11 phase kept");
    idle(GAP);
    chk("R11 long gap", int'(locked), 0);
  endtask

  task automatic t_sparse();
    logic [32:0] pre = 33'h0_AAAA_AAAA;
    do_resync();
    for (int i = 32; i >= 0; i--) begin slot(pre[i]); idle(1 + i % 2); end
    for (int i = 15; i >= 0; i--) begin slot(W_DAT[i]); if (i != 0) idle(2); end
    chk("R12 sparse lock", int'(locked), 1);
    chk("R12 sparse kind", int'(mark_kind), 1);
  endtask

  initial begin
    rst_n = 1'b0; slot_stb = 1'b0; chan_bit = 1'b0; resync = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_header();
    t_data();
    t_short();
    t_no_run();
    t_legal();
    t_late();
    t_locked_mark();
    t_resync();
    t_gap();
    t_sparse();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule